// File: doc/BRIEF.md
# Stream FIFO Single-Bit Integrity Monitor

This block sits next to a stream FIFO, taps both of its valid/ready handshakes and its data buses, and reports whether one chosen data bit came out of the FIFO in the order it went in. Each accepted write beat records the probed bit in a small bit-wide shadow queue. Each accepted read beat compares the probed bit of the read data with the oldest recorded bit and removes that bit from the queue.

The monitor drives no handshake signal and applies no back-pressure. A beat counts only when valid and ready are both high at a rising clock edge. A side with valid high and ready low is stalled, and the monitor ignores it. Any disagreement, and any read beat that has nothing to compare against, sets a sticky error pin. That pin suits a logic analyser trigger. The check is switched in or out, and the probed bit chosen, through parameters. Reset is synchronous and active high.

Top module: `fifo_bit_tracker`

## Requirements
- R1: With CHECK_EN = 0 the block has no storage, and err_flag is 0 whatever the inputs do.
- R2: Only bit PROBE_BIT of in_data and out_data is observed. Differences in any other bit position never set err_flag.
- R3: A probed bit is recorded only on a write beat (in_valid and in_ready both 1). in_valid with in_ready low records nothing.
- R4: On a read beat (out_valid and out_ready both 1) the probed output bit is compared with the oldest recorded bit. A mismatch makes err_flag read 1 from the clock edge that accepts the beat onward. out_valid with out_ready low compares nothing.
- R5: The shadow queue holds FIFO_DEPTH + PIPE_DEPTH bits and releases them in first-in first-out order.
- R6: When a write beat and a read beat occur in the same cycle on a non-empty queue, one bit enters and one leaves, and the occupancy does not change.
- R7: Once set, err_flag stays 1 until reset, whatever traffic follows.
- R8: A read beat taken while the queue is empty sets err_flag. A write beat in that same cycle is still recorded.
- R9: A write beat while the queue is full, with no read beat in the same cycle, is discarded.
- R10: Reset empties the shadow queue and clears err_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Valid of the monitored FIFO's write side |
| in_ready | input | 1 | Ready of the monitored FIFO's write side |
| in_data | input | DATA_W | Data of the monitored FIFO's write side |
| out_valid | input | 1 | Valid of the monitored FIFO's read side |
| out_ready | input | 1 | Ready of the monitored FIFO's read side |
| out_data | input | DATA_W | Data of the monitored FIFO's read side |
| err_flag | output | 1 | Sticky integrity error |

## Verification
The hardest state to reach is the full shadow queue receiving one more write. A real FIFO never does this, so it is reached only because the bench drives both handshakes itself, with no FIFO in between. The bench fills six entries, adds a seventh write, and drains. The drop is visible at the ports only as an error on the extra read. The empty-queue read that coincides with a write is built the same way, and the bit from that write is then drained to show that it was kept.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

  function automatic int unsigned ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } shadow_op_e;

endpackage

// File: rtl/fbt_shadow_q.sv
module fbt_shadow_q
  import fbt_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic din,
  output logic head,
  output logic empty,
  output logic full
);
  localparam int unsigned PW = ptr_w(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DEPTH-1:0] bits_q;
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;
  shadow_op_e       op;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign op      = shadow_op_e'({do_push, do_pop});
  assign head    = bits_q[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) bits_q[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= adv(wr_q);
      if (do_pop)  rd_q <= adv(rd_q);
      unique case (op)
        OP_PUSH: cnt_q <= cnt_q + CW'(1);
        OP_POP:  cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fbt_flag.sv
module fbt_flag (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  input  logic shadow_empty,
  input  logic expect_bit,
  input  logic seen_bit,
  output logic err
);
  logic bad_beat;

  assign bad_beat = beat & (shadow_empty | (expect_bit != seen_bit));

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= err | bad_beat;
  end
endmodule

// File: rtl/fifo_bit_tracker.sv
module fifo_bit_tracker #(
  parameter bit          CHECK_EN   = 1'b1,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned PROBE_BIT  = 16,
  parameter int unsigned FIFO_DEPTH = 14,
  parameter int unsigned PIPE_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_valid,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] out_data,
  output logic              err_flag
);
  localparam int unsigned SHADOW_DEPTH = FIFO_DEPTH + PIPE_DEPTH;

  // Only one bit of each bus is probed; the rest are deliberately ignored.
  logic sig_unused;
  assign sig_unused = ^{in_data, out_data, in_valid, in_ready, out_valid, out_ready, rst};

  if (CHECK_EN) begin : g_on
    logic wr_beat, rd_beat, head_bit, q_empty, q_full;

    assign wr_beat = in_valid & in_ready;
    assign rd_beat = out_valid & out_ready;

    fbt_shadow_q #(.DEPTH(SHADOW_DEPTH)) u_q (
      .clk   (clk),
      .rst   (rst),
      .push  (wr_beat),
      .pop   (rd_beat),
      .din   (in_data[PROBE_BIT]),
      .head  (head_bit),
      .empty (q_empty),
      .full  (q_full)
    );

    fbt_flag u_flag (
      .clk          (clk),
      .rst          (rst),
      .beat         (rd_beat),
      .shadow_empty (q_empty),
      .expect_bit   (head_bit),
      .seen_bit     (out_data[PROBE_BIT]),
      .err          (err_flag)
    );

    logic full_unused;
    assign full_unused = q_full;
  end else begin : g_off
    assign err_flag = 1'b0;
  end
endmodule

// File: rtl/fbt_checker.sv
module fbt_checker #(
  parameter bit          ENABLE = 1'b1,
  parameter int unsigned DEPTH  = 16
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic err_flag
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  logic          wr, rd;
  logic [CW-1:0] occ;

  assign wr = in_valid & in_ready;
  assign rd = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else if (wr && !(rd && occ != '0) && occ != TOP) occ <= occ + CW'(1);
    else if (rd && occ != '0 && !wr) occ <= occ - CW'(1);
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R7

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> !err_flag); // R10

  AST_RISE_ON_BEAT: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> $past(out_valid && out_ready)); // R4

  AST_EMPTY_BEAT: assert property (@(posedge clk) disable iff (rst)
    (ENABLE && occ == '0 && rd) |=> err_flag); // R8

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ENABLE && rd) |=> !err_flag); // R1
endmodule

bind fifo_bit_tracker fbt_checker #(
  .ENABLE (CHECK_EN),
  .DEPTH  (FIFO_DEPTH + PIPE_DEPTH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .err_flag  (err_flag)
);

// File: tb/fifo_bit_tracker_tb_top.sv
module fifo_bit_tracker_tb_top;
  localparam int unsigned DW = 32;
  localparam int unsigned PB = 5;
  localparam int unsigned QD = 6;  // 4 + 2

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_ready = 0, out_valid = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0, out_data = '0;
  logic err_on, err_off;

  int n_vec = 0;
  int n_bad = 0;
  int salt  = 1;
  bit done  = 0;
  bit exp_err = 0;
  bit sb_q[$];

  always #10 clk = ~clk;

  fifo_bit_tracker #(.CHECK_EN(1'b1), .DATA_W(DW), .PROBE_BIT(PB),
                     .FIFO_DEPTH(4), .PIPE_DEPTH(2)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .err_flag(err_on));

  fifo_bit_tracker #(.CHECK_EN(1'b0), .DATA_W(DW), .PROBE_BIT(PB),
                     .FIFO_DEPTH(4), .PIPE_DEPTH(2)) dut_off_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .err_flag(err_off));

  function automatic logic [DW-1:0] mk(input bit b, input int s);
    logic [DW-1:0] d;
    d = DW'(32'h9E37_79B9 * s) ^ DW'(32'hA5C3_0F1E);
    d[PB] = b;
    return d;
  endfunction

  task automatic chk(input string req, input bit act, input bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: err_flag actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of handshakes, updates the scoreboard, then checks.
  task automatic step(input bit iv, input bit ir, input bit ib,
                      input bit ov, input bit orr, input bit ob, input string req);
    bit wr, rd, emp, ful, pop_ok;
    in_valid = iv; in_ready = ir; in_data = mk(ib, salt); salt++;
    out_valid = ov; out_ready = orr; out_data = mk(ob, salt); salt++;
    if (rst) begin
      sb_q.delete();
      exp_err = 0;
    end else begin
      wr = iv & ir; rd = ov & orr;
      emp = (sb_q.size() == 0); ful = (sb_q.size() == QD);
      pop_ok = rd && !emp;
      if (rd) begin
        if (emp) exp_err = 1;
        else if (sb_q[0] != ob) exp_err = 1;
      end
      if (pop_ok) void'(sb_q.pop_front());
      if (wr && (!ful || pop_ok)) sb_q.push_back(ib);
    end
    @(negedge clk);
    chk(req, err_on, exp_err);
    chk("R1", err_off, 1'b0);
  endtask

  task automatic wr1(input bit b, input string req); step(1,1,b, 0,0,0, req); endtask
  task automatic rd1(input bit b, input string req); step(0,0,0, 1,1,b, req); endtask
  task automatic idle(input string req); step(0,0,0, 0,0,0, req); endtask

  task automatic do_reset();
    rst = 1;
    idle("R10");
    idle("R10");
    rst = 0;
    idle("R10");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R5: fill the full depth and drain in order
    wr1(1,"R5"); wr1(0,"R5"); wr1(0,"R5"); wr1(1,"R5"); wr1(1,"R5"); wr1(0,"R5");
    rd1(1,"R5"); rd1(0,"R5"); rd1(0,"R5"); rd1(1,"R5"); rd1(1,"R5"); rd1(0,"R5");

    // R3: unaccepted write of 0 must not be recorded
    step(1,0,0, 0,0,0, "R3");
    wr1(1,"R3");
    rd1(1,"R3");

    // R2: other bits always differ between write and read data
    wr1(0,"R2"); idle("R2"); rd1(0,"R2");

    // R4: stalled read with a wrong bit compares nothing
    wr1(1,"R4");
    step(0,0,0, 1,0,0, "R4");
    rd1(1,"R4");

    // R6: simultaneous beats keep occupancy and order
    wr1(1,"R6"); wr1(0,"R6");
    step(1,1,1, 1,1,1, "R6");
    step(1,1,0, 1,1,0, "R6");
    step(1,1,0, 1,1,1, "R6");
    rd1(0,"R6"); rd1(0,"R6");
    idle("R6");

    // R9: seventh write on a full queue is dropped, extra read is then empty
    for (int i = 0; i < 6; i++) wr1(i[0], "R9");
    wr1(1,"R9");
    for (int i = 0; i < 6; i++) rd1(i[0], "R9");
    rd1(1,"R9");
    idle("R9");

    // R10: reset clears error and occupancy
    do_reset();
    wr1(1,"R10");
    do_reset();
    rd1(1,"R10");
    do_reset();

    // R8: empty read with a simultaneous write; the written bit is kept
    step(1,1,1, 1,1,0, "R8");
    rd1(1,"R8");
    idle("R8");
    do_reset();

    // R4 and R7: mismatch sets the flag, which then holds
    wr1(1,"R4");
    rd1(0,"R4");
    wr1(0,"R7"); rd1(0,"R7"); idle("R7"); idle("R7");
    do_reset();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule